// File: doc/BRIEF.md
# Branch Next-Address and Link Generator

This block sits in the fetch redirect path of a 64-bit core with 32-bit instructions. For each instruction presented with `req_valid`, it decodes which of four branch forms the word holds. It then works out the address execution continues from and, when asked, the return address to store in the link register. The four forms are:

- a long-reach unconditional branch with an immediate displacement;
- a short-reach conditional branch with an immediate displacement;
- a conditional jump through the link register;
- a conditional jump through the count register.

The decision whether a conditional branch is taken comes from a separate condition unit through `taken_in`. This block does not evaluate conditions and does not predict.

Results are registered. A small controller has two states. `ST_IDLE` means nothing is being presented. `ST_EMIT` means the output registers hold the result of the request sampled at the previous edge. The transitions are:

- `ST_IDLE` goes to `ST_EMIT` when `req_valid` is sampled high.
- `ST_EMIT` stays in `ST_EMIT` while requests keep arriving back to back.
- `ST_EMIT` goes back to `ST_IDLE` on the first edge with `req_valid` low.

The link and count values are read from the request-cycle inputs. A target taken from the link register therefore always uses the value from before the write this same instruction may request.

Top module: `branch_nextpc`

## Requirements
- R1: Primary opcode 18 (instruction bits [31:26]) is the long immediate form. Its 24-bit displacement in bits [25:2] gets two zero bits appended and is sign-extended to 64 bits. The branch is taken whatever `taken_in` says.
- R2: Primary opcode 16 is the short immediate form. Its 14-bit displacement in bits [15:2] gets two zero bits appended and is sign-extended to 64 bits. The branch is taken only when `taken_in` is 1.
- R3: For opcodes 16 and 18, the absolute bit is bit [1]. When it is 0 the target is the aligned current address plus the offset, wrapping modulo 2^64. When it is 1 the sign-extended offset itself is the target.
- R4: Opcode 19 with extended opcode 16 (bits [10:1]) branches, when taken, to the link-register input with its low two bits cleared. This uses the pre-update value even when the same instruction writes the link register.
- R5: Opcode 19 with extended opcode 528 branches, when taken, to the count-register input with its low two bits cleared.
- R6: On any of the four forms with bit [0] set, `link_we` is 1 and `link_value` is the aligned current address plus 4. This holds whether or not the branch is taken.
- R7: A conditional form (opcode 16, or opcode 19 with extended opcode 16 or 528) with `taken_in` 0 yields the aligned current address plus 4.
- R8: Any other opcode, or opcode 19 with another extended opcode, yields the aligned current address plus 4 with `link_we` 0. In that case bit [0] has no effect.
- R9: The low two bits of `cia_in` are treated as zero, and `next_addr[1:0]` is always 0.
- R10: Results appear with `out_valid` 1 on the edge after the request is sampled, and back-to-back requests give back-to-back results. After reset, and in any cycle without a preceding request, `out_valid` and `link_we` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| instr_in | input | 32 | Instruction word |
| cia_in | input | 64 | Address of the instruction |
| lr_in | input | 64 | Current link register value |
| ctr_in | input | 64 | Current count register value |
| taken_in | input | 1 | Branch condition outcome from the condition unit |
| out_valid | output | 1 | Result registers hold a fresh result |
| next_addr | output | 64 | Address to fetch next |
| link_value | output | 64 | Value to write into the link register |
| link_we | output | 1 | Link register write enable |

## Verification
The hardest case to reach from the ports is where offset arithmetic crosses the ends of the 64-bit address space. This happens when a negative displacement sits at a low address or a positive one at the top of memory. It matters most for the most negative displacement of each width, and it must coincide with a link write that would overwrite the register being used as a source. The stimulus sweeps every form against every flag combination. It crosses that sweep with displacement patterns at both sign extremes and with current addresses at zero, mid-range, at the last aligned word, and unaligned. This forces the wrap and the read-before-write cases into the same vectors.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

    localparam int OPC_W      = 6;
    localparam int XO_W       = 10;
    localparam int OPC_IMM    = 18;
    localparam int OPC_COND   = 16;
    localparam int OPC_XL     = 19;
    localparam int XO_TO_LR   = 16;
    localparam int XO_TO_CTR  = 528;

    typedef enum logic [2:0] {
        FORM_NONE,
        FORM_IMM,
        FORM_COND,
        FORM_LR,
        FORM_CTR
    } form_e;

    typedef struct packed {
        form_e form;
        logic  abs_mode;
        logic  link;
    } dec_t;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } state_e;

endpackage

// File: rtl/bnpc_decode.sv
module bnpc_decode
    import bnpc_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    localparam int OPC_LSB = INSTR_W - OPC_W;

    logic [OPC_W-1:0] opcode;
    logic [XO_W-1:0]  xo;

    assign opcode = instr[OPC_LSB +: OPC_W];
    assign xo     = instr[1 +: XO_W];

    always_comb begin
        dec.form     = FORM_NONE;
        dec.abs_mode = 1'b0;
        dec.link     = 1'b0;
        unique case (opcode)
            OPC_W'(OPC_IMM): begin
                dec.form     = FORM_IMM;
                dec.abs_mode = instr[1];
                dec.link     = instr[0];
            end
            OPC_W'(OPC_COND): begin
                dec.form     = FORM_COND;
                dec.abs_mode = instr[1];
                dec.link     = instr[0];
            end
            OPC_W'(OPC_XL): begin
                if (xo == XO_W'(XO_TO_LR)) begin
                    dec.form = FORM_LR;
                    dec.link = instr[0];
                end else if (xo == XO_W'(XO_TO_CTR)) begin
                    dec.form = FORM_CTR;
                    dec.link = instr[0];
                end
            end
            default: begin
                dec.form = FORM_NONE;
            end
        endcase
    end
endmodule

// File: rtl/bnpc_sext.sv
module bnpc_sext #(
    parameter int IN_W  = 24,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  disp,
    output logic [OUT_W-1:0] offset
);
    localparam int FULL_W = IN_W + 2;
    localparam int PAD_W  = OUT_W - FULL_W;

    logic [FULL_W-1:0] scaled;

    assign scaled = {disp, 2'b00};
    assign offset = {{PAD_W{scaled[FULL_W-1]}}, scaled};
endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
    import bnpc_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int INSTR_W     = 32,
    parameter int LONG_W      = 24,
    parameter int SHORT_W     = 14,
    parameter int INSTR_BYTES = 4
) (
    input  dec_t               dec,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  cia_al,
    input  logic [ADDR_W-1:0]  lr_val,
    input  logic [ADDR_W-1:0]  ctr_val,
    input  logic               taken,
    output logic [ADDR_W-1:0]  next_addr,
    output logic [ADDR_W-1:0]  seq_addr,
    output logic               link_req
);
    localparam int N_IMM = 2;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(INSTR_BYTES - 1);

    logic [N_IMM-1:0][ADDR_W-1:0] offs;

    for (genvar gi = 0; gi < N_IMM; gi++) begin : g_ext
        localparam int W = (gi == 0) ? LONG_W : SHORT_W;
        bnpc_sext #(
            .IN_W  (W),
            .OUT_W (ADDR_W)
        ) u_sext (
            .disp   (instr[2 +: W]),
            .offset (offs[gi])
        );
    end

    logic [ADDR_W-1:0] tgt;
    logic              take;

    assign seq_addr = cia_al + ADDR_W'(INSTR_BYTES);

    always_comb begin
        tgt  = seq_addr;
        take = 1'b0;
        unique case (dec.form)
            FORM_IMM: begin
                tgt  = dec.abs_mode ? offs[0] : cia_al + offs[0];
                take = 1'b1;
            end
            FORM_COND: begin
                tgt  = dec.abs_mode ? offs[1] : cia_al + offs[1];
                take = taken;
            end
            FORM_LR: begin
                tgt  = lr_val & ALIGN_MASK;
                take = taken;
            end
            FORM_CTR: begin
                tgt  = ctr_val & ALIGN_MASK;
                take = taken;
            end
            default: begin
                tgt  = seq_addr;
                take = 1'b0;
            end
        endcase
    end

    assign next_addr = take ? tgt : seq_addr;
    assign link_req  = (dec.form != FORM_NONE) && dec.link;
endmodule

// File: rtl/branch_nextpc.sv
module branch_nextpc
    import bnpc_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int INSTR_W     = 32,
    parameter int LONG_W      = 24,
    parameter int SHORT_W     = 14,
    parameter int INSTR_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [INSTR_W-1:0] instr_in,
    input  logic [ADDR_W-1:0]  cia_in,
    input  logic [ADDR_W-1:0]  lr_in,
    input  logic [ADDR_W-1:0]  ctr_in,
    input  logic               taken_in,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  next_addr,
    output logic [ADDR_W-1:0]  link_value,
    output logic               link_we
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(INSTR_BYTES - 1);
    localparam int OPC_LSB = INSTR_W - OPC_W;

    state_e state_q, state_d;
    dec_t   dec;

    logic [ADDR_W-1:0] cia_al;
    logic [ADDR_W-1:0] nxt_c, seq_c;
    logic              link_c;
    logic [ADDR_W-1:0] nxt_q, lv_q;
    logic              link_q;

    assign cia_al = cia_in & ALIGN_MASK;

    bnpc_decode #(.INSTR_W(INSTR_W)) u_dec (
        .instr (instr_in),
        .dec   (dec)
    );

    bnpc_target #(
        .ADDR_W      (ADDR_W),
        .INSTR_W     (INSTR_W),
        .LONG_W      (LONG_W),
        .SHORT_W     (SHORT_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_tgt (
        .dec       (dec),
        .instr     (instr_in),
        .cia_al    (cia_al),
        .lr_val    (lr_in),
        .ctr_val   (ctr_in),
        .taken     (taken_in),
        .next_addr (nxt_c),
        .seq_addr  (seq_c),
        .link_req  (link_c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q  <= '0;
            lv_q   <= '0;
            link_q <= 1'b0;
        end else if (req_valid) begin
            nxt_q  <= nxt_c;
            lv_q   <= seq_c;
            link_q <= link_c;
        end
    end

    assign out_valid  = (state_q == ST_EMIT);
    assign next_addr  = nxt_q;
    assign link_value = lv_q;
    assign link_we    = out_valid && link_q;

    p_valid_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid));

    p_we_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> out_valid);

    p_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (next_addr[1:0] == 2'b00));

    p_link_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_value == ($past(cia_in) & ALIGN_MASK) + ADDR_W'(INSTR_BYTES)));

    p_cond_not_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(!taken_in && instr_in[OPC_LSB +: OPC_W] == OPC_W'(OPC_COND)))
        |-> (next_addr == ($past(cia_in) & ALIGN_MASK) + ADDR_W'(INSTR_BYTES)));

    p_lr_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(taken_in && instr_in[OPC_LSB +: OPC_W] == OPC_W'(OPC_XL)
                            && instr_in[1 +: XO_W] == XO_W'(XO_TO_LR)))
        |-> (next_addr == ($past(lr_in) & ALIGN_MASK)));
endmodule

// File: tb/test_branch_nextpc.sv
module test_branch_nextpc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] instr_in = '0;
    logic [63:0] cia_in = '0, lr_in = '0, ctr_in = '0;
    logic        taken_in = 1'b0;
    logic        out_valid, link_we;
    logic [63:0] next_addr, link_value;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_nextpc i_branch_nextpc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr_in(instr_in),
        .cia_in(cia_in), .lr_in(lr_in), .ctr_in(ctr_in), .taken_in(taken_in),
        .out_valid(out_valid), .next_addr(next_addr), .link_value(link_value),
        .link_we(link_we)
    );

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] disp_pat(input int p, input int w);
        longint one = 1;
        case (p)
            0: return 24'(0);
            1: return 24'(1);
            2: return 24'((one << (w-1)) - 1);
            3: return 24'(one << (w-1));
            4: return 24'((one << w) - 1);
            default: return 24'(64'h5A5A_A5A5 & ((one << w) - 1));
        endcase
    endfunction

    function automatic logic [63:0] cia_pat(input int c);
        case (c)
            0: return 64'h0;
            1: return 64'h0000_0000_0100_0000;
            2: return 64'hFFFF_FFFF_FFFF_FFFC;
            default: return 64'h1234_5678_9ABC_DEF3;
        endcase
    endfunction

    logic [63:0] e_next, e_lv;
    bit          e_we, have_prev;
    string       e_tag;

    task automatic apply(input int f, input bit aa, input bit lk, input bit tk,
                         input int p, input int c, input int k);
        logic [63:0] ca, seq, off;
        logic [23:0] d;
        longint      sd;
        bit          take, branchy;
        string       tag;
        ca  = cia_pat(c);
        seq = (ca & ~64'h3) + 64'd4;
        lr_in  = 64'hCAFE_0000_0000_0001 + 64'(k) * 64'd13;
        ctr_in = 64'h8000_1234_0000_0002 + 64'(k) * 64'd7;
        take = 1'b0; branchy = 1'b1; off = seq;
        case (f)
            0: begin
                d = disp_pat(p, 24);
                instr_in = {6'd18, d, aa, lk};
                sd = longint'($signed(d)) * 4;
                off = aa ? 64'(sd) : (ca & ~64'h3) + 64'(sd);
                take = 1'b1; tag = aa ? "R1/R3 abs" : "R1/R3 rel";
            end
            1: begin
                d = disp_pat(p, 14);
                instr_in = {6'd16, 10'h2A5, d[13:0], aa, lk};
                sd = longint'($signed(d[13:0])) * 4;
                off = aa ? 64'(sd) : (ca & ~64'h3) + 64'(sd);
                take = tk; tag = tk ? "R2/R3" : "R7 cond";
            end
            2: begin
                instr_in = {6'd19, 5'd20, 5'd3, 5'(p), 10'd16, lk};
                off = lr_in & ~64'h3; take = tk; tag = tk ? "R4" : "R7 lr";
            end
            3: begin
                instr_in = {6'd19, 5'd12, 5'd1, 5'(p), 10'd528, lk};
                off = ctr_in & ~64'h3; take = tk; tag = tk ? "R5" : "R7 ctr";
            end
            4: begin
                instr_in = {6'd19, 15'h1234, 10'd150, lk};
                branchy = 1'b0; tag = "R8 xl";
            end
            default: begin
                instr_in = {6'd31, 24'(p * 77 + c), aa, lk};
                branchy = 1'b0; tag = "R8 other";
            end
        endcase
        cia_in   = ca;
        taken_in = tk;
        e_next = take ? off : seq;
        e_we   = branchy && lk;
        e_lv   = seq;
        e_tag  = tag;
    endtask

    task automatic check_prev();
        check64({e_tag, " next_addr"}, next_addr, e_next);
        check64("R9 next_addr align", 64'(next_addr[1:0]), 64'd0);
        check64("R10 out_valid", 64'(out_valid), 64'd1);
        check64({e_tag, " R6/R8 link_we"}, 64'(link_we), 64'(e_we));
        if (e_we) check64("R6 link_value", link_value, e_lv);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        check64("R10 reset out_valid", 64'(out_valid), 64'd0);
        check64("R10 reset link_we", 64'(link_we), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R10 idle out_valid", 64'(out_valid), 64'd0);
        k = 0;
        have_prev = 1'b0;
        for (int f = 0; f < 6; f++)
            for (int aa = 0; aa < 2; aa++)
                for (int lk = 0; lk < 2; lk++)
                    for (int tk = 0; tk < 2; tk++)
                        for (int p = 0; p < 6; p++)
                            for (int c = 0; c < 4; c++) begin
                                if (have_prev) check_prev();
                                req_valid = 1'b1;
                                apply(f, aa[0], lk[0], tk[0], p, c, k);
                                have_prev = 1'b1;
                                k++;
                                @(negedge clk);
                            end
        check_prev();
        req_valid = 1'b0;
        instr_in  = {6'd18, 24'd4, 1'b0, 1'b1};
        @(negedge clk);
        check64("R10 gap out_valid", 64'(out_valid), 64'd0);
        check64("R10 gap link_we", 64'(link_we), 64'd0);
        req_valid = 1'b1;
        apply(2, 1'b0, 1'b1, 1'b1, 3, 2, k);
        @(negedge clk);
        req_valid = 1'b0;
        check_prev();
        @(negedge clk);
        check64("R10 drop out_valid", 64'(out_valid), 64'd0);
        finish_run();
    end
endmodule